// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This peripheral drives a chain of external serial-in, parallel-out shift registers, such as a bank of status LEDs. Software loads a 24-bit output image through a small 32-bit register bus. The image is organised as three 8-bit groups, and software chooses which groups are present in the chain. On each refresh the controller clocks the enabled bits out on a data pin and a shift-clock pin, starting with the most significant enabled bit. After the last clock edge it raises a one-cycle store strobe, which moves the shifted pattern onto the parallel outputs.

A refresh can be started in two ways. Software can request one with a register write. A free-running timer, clocked from the bus clock, can also start refreshes at one of four fixed rates. The low eight output bits can be owned by hardware on a per-bit basis. Two of these bits follow a modem status input. Two further 3-bit slices follow the status inputs of two PHYs. The values of these owned bits are captured when each refresh starts. The shift clock can be set up for registers that sample on either the rising or the falling edge.

Top module: `led_shift_ctrl`

## Requirements
- R1: After reset, every register reads zero except control 0, which reads 0x0400_0000. The shift clock rests high, and both store and data rest low.
- R2: Control 0 (offset 0x00), control 1 (0x04), data 0 (0x08), data 1 (0x0C) and the access word (0x10) each read back the last full 32-bit value written to them.
- R3: A write to control 0 with bit 31 set starts one refresh. A write to data 0 starts one refresh only while control 0 bit 31 is already set. A write to data 0 while that bit is clear starts nothing.
- R4: The frame length is 8 times the index (1 to 3) of the highest set bit of control 1 bits 2:0. When those bits are zero, a trigger produces no clock edges and no store strobe.
- R5: Bits go out most significant first. Data is stable at each sampling edge. After the last edge comes exactly one store strobe, one clock cycle wide.
- R6: When control 0 bit 26 is 1, the shift clock idles high and the external registers sample on its falling edge. When the bit is 0, the clock idles low and they sample on its rising edge.
- R7: For each output bit k in 1:0, the refresh sends modem input bit k instead of data bit k when control 0 bit 24+k is set.
- R8: For each k in 2:0, control 0 bit 27+k gives output bit 2+k to PHY A input bit k. For each k in 2:0, control 1 bit 15+k gives output bit 5+k to PHY B input bit k.
- R9: When control 1 bits 31:30 equal 10, a refresh starts every CLK_HZ/f cycles. The rate f is 2, 4, 8 or 10, selected by control 1 bits 24:23 = 00, 01, 10 or 11. Any other value of bits 31:30 stops automatic refreshes.
- R10: A trigger that arrives while a refresh is in progress is ignored. It does not restart the refresh and does not add a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write qualifier for bus_en |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| modem_led | input | 2 | Live modem status for output bits 1:0 |
| phy_a_led | input | 3 | Live PHY A status for output bits 4:2 |
| phy_b_led | input | 3 | Live PHY B status for output bits 7:5 |
| sh_clk | output | 1 | Shift clock to the register chain |
| sh_data | output | 1 | Serial data to the register chain |
| sh_store | output | 1 | Store/latch strobe |

## Verification
The bench builds the block with CLK_HZ = 800 and PHASE_CYC = 2. With these values the four automatic periods are 400, 200, 100 and 80 cycles, so the spacing between consecutive store strobes can be measured exactly within a few hundred cycles. A full 24-bit frame takes under a hundred cycles. This makes room for frames of every length, both clock polarities, a trigger sent mid-frame, and a change of rate, all within one short run.

// File: rtl/led_shift_pkg.sv
package led_shift_pkg;
    localparam int IMG_W   = 24;
    localparam int GROUPS  = 3;
    localparam int GROUP_W = 8;

    localparam logic [4:0] OFS_CTL0 = 5'h00;
    localparam logic [4:0] OFS_CTL1 = 5'h04;
    localparam logic [4:0] OFS_DAT0 = 5'h08;
    localparam logic [4:0] OFS_DAT1 = 5'h0C;
    localparam logic [4:0] OFS_ACC  = 5'h10;

    localparam int C0_SWMODE = 31;
    localparam int C0_EDGE   = 26;
    localparam int C0_MODEM  = 24;
    localparam int C0_PHYA   = 27;
    localparam int C1_PHYB   = 15;
    localparam int C1_RATE   = 23;
    localparam int C1_SRC    = 30;

    localparam logic [31:0] CTL0_RST = 32'h0400_0000;

    typedef enum logic [1:0] {
        SH_IDLE,
        SH_SETUP,
        SH_ACTIVE,
        SH_STORE
    } sh_state_e;
endpackage

// File: rtl/led_shift_regs.sv
module led_shift_regs
    import led_shift_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [4:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                falling_o,
    output logic [1:0]          modem_en_o,
    output logic [2:0]          phya_en_o,
    output logic [2:0]          phyb_en_o,
    output logic [GROUPS-1:0]   group_en_o,
    output logic [1:0]          rate_o,
    output logic                auto_en_o,
    output logic [IMG_W-1:0]    image_o,
    output logic                sw_trig_o
);
    typedef struct packed {
        logic [31:0] ctl0;
        logic [31:0] ctl1;
        logic [31:0] dat0;
        logic [31:0] dat1;
        logic [31:0] acc;
        logic        sw_trig;
    } regs_t;

    regs_t r_q, r_d;
    logic  wr;

    assign wr = bus_en && bus_we;

    always_comb begin
        r_d = r_q;
        r_d.sw_trig = 1'b0;
        if (wr) begin
            case (bus_addr)
                OFS_CTL0: begin
                    r_d.ctl0 = bus_wdata;
                    r_d.sw_trig = bus_wdata[C0_SWMODE];
                end
                OFS_CTL1: r_d.ctl1 = bus_wdata;
                OFS_DAT0: begin
                    r_d.dat0 = bus_wdata;
                    r_d.sw_trig = r_q.ctl0[C0_SWMODE];
                end
                OFS_DAT1: r_d.dat1 = bus_wdata;
                OFS_ACC:  r_d.acc  = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
            r_q.ctl0 <= CTL0_RST;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTL0: bus_rdata = r_q.ctl0;
            OFS_CTL1: bus_rdata = r_q.ctl1;
            OFS_DAT0: bus_rdata = r_q.dat0;
            OFS_DAT1: bus_rdata = r_q.dat1;
            OFS_ACC:  bus_rdata = r_q.acc;
            default:  bus_rdata = '0;
        endcase
    end

    assign falling_o  = r_q.ctl0[C0_EDGE];
    assign modem_en_o = r_q.ctl0[C0_MODEM +: 2];
    assign phya_en_o  = r_q.ctl0[C0_PHYA +: 3];
    assign phyb_en_o  = r_q.ctl1[C1_PHYB +: 3];
    assign group_en_o = r_q.ctl1[GROUPS-1:0];
    assign rate_o     = r_q.ctl1[C1_RATE +: 2];
    assign auto_en_o  = (r_q.ctl1[C1_SRC +: 2] == 2'b10);
    assign image_o    = r_q.dat0[IMG_W-1:0];
    assign sw_trig_o  = r_q.sw_trig;

    AST_SW_TRIG_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig_o |-> $past(bus_en && bus_we)); // R3
endmodule

// File: rtl/led_shift_timer.sv
module led_shift_timer #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic [1:0] rate_i,
    output logic       tick_o
);
    localparam int CNT_W = $clog2(CLK_HZ / 2 + 1);
    localparam int LIM0  = CLK_HZ / 2;
    localparam int LIM1  = CLK_HZ / 4;
    localparam int LIM2  = CLK_HZ / 8;
    localparam int LIM3  = CLK_HZ / 10;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } tmr_t;

    tmr_t t_q, t_d;
    logic [CNT_W-1:0] lim_m1;

    always_comb begin
        case (rate_i)
            2'b00:   lim_m1 = CNT_W'(LIM0 - 1);
            2'b01:   lim_m1 = CNT_W'(LIM1 - 1);
            2'b10:   lim_m1 = CNT_W'(LIM2 - 1);
            default: lim_m1 = CNT_W'(LIM3 - 1);
        endcase
    end

    always_comb begin
        t_d = t_q;
        t_d.tick = 1'b0;
        if (!en_i) begin
            t_d.cnt = '0;
        end else if (t_q.cnt >= lim_m1) begin
            t_d.cnt  = '0;
            t_d.tick = 1'b1;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tick_o = t_q.tick;

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o); // R9
endmodule

// File: rtl/led_shift_seq.sv
module led_shift_seq
    import led_shift_pkg::*;
#(
    parameter int PHASE_CYC = 4,
    parameter int NB_W      = $clog2(IMG_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NB_W-1:0]  nbits_i,
    input  logic [IMG_W-1:0] img_i,
    input  logic             falling_i,
    output logic             sh_clk_o,
    output logic             sh_data_o,
    output logic             sh_store_o
);
    localparam int PH_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam int IX_W = $clog2(IMG_W);

    typedef struct packed {
        sh_state_e        st;
        logic [IMG_W-1:0] img;
        logic [IX_W-1:0]  idx;
        logic [PH_W-1:0]  cnt;
    } seq_t;

    seq_t s_q, s_d;
    logic ph_end;

    assign ph_end = (s_q.cnt == PH_W'(PHASE_CYC - 1));

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            SH_IDLE: begin
                if (start_i && nbits_i != '0) begin
                    s_d.img = img_i;
                    s_d.idx = IX_W'(nbits_i - 1'b1);
                    s_d.cnt = '0;
                    s_d.st  = SH_SETUP;
                end
            end
            SH_SETUP: begin
                if (ph_end) begin
                    s_d.cnt = '0;
                    s_d.st  = SH_ACTIVE;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            SH_ACTIVE: begin
                if (ph_end) begin
                    s_d.cnt = '0;
                    if (s_q.idx == '0) begin
                        s_d.st = SH_STORE;
                    end else begin
                        s_d.idx = s_q.idx - 1'b1;
                        s_d.st  = SH_SETUP;
                    end
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d.st = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SH_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign sh_clk_o   = (s_q.st == SH_ACTIVE) ^ falling_i;
    assign sh_data_o  = (s_q.st != SH_IDLE) ? s_q.img[s_q.idx] : 1'b0;
    assign sh_store_o = (s_q.st == SH_STORE);

    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store_o |=> !sh_store_o); // R5
    AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != SH_IDLE && start_i) |=> (s_q.img == $past(s_q.img))); // R10
    AST_EMPTY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SH_IDLE && start_i && nbits_i == '0) |=> (s_q.st == SH_IDLE)); // R4
endmodule

// File: rtl/led_shift_ctrl.sv
module led_shift_ctrl
    import led_shift_pkg::*;
#(
    parameter int CLK_HZ    = 100_000_000,
    parameter int PHASE_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_en,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [1:0]  modem_led,
    input  logic [2:0]  phy_a_led,
    input  logic [2:0]  phy_b_led,
    output logic        sh_clk,
    output logic        sh_data,
    output logic        sh_store
);
    localparam int NB_W = $clog2(IMG_W + 1);

    logic              falling, auto_en, sw_trig, tick;
    logic [1:0]        modem_en, rate;
    logic [2:0]        phya_en, phyb_en;
    logic [GROUPS-1:0] group_en;
    logic [IMG_W-1:0]  image, img_ovr;
    logic [NB_W-1:0]   nbits;

    led_shift_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .falling_o  (falling),
        .modem_en_o (modem_en),
        .phya_en_o  (phya_en),
        .phyb_en_o  (phyb_en),
        .group_en_o (group_en),
        .rate_o     (rate),
        .auto_en_o  (auto_en),
        .image_o    (image),
        .sw_trig_o  (sw_trig)
    );

    led_shift_timer #(.CLK_HZ(CLK_HZ)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (auto_en),
        .rate_i (rate),
        .tick_o (tick)
    );

    always_comb begin
        nbits = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (group_en[g]) nbits = NB_W'(GROUP_W * (g + 1));
        end
    end

    always_comb begin
        img_ovr = image;
        for (int k = 0; k < 2; k++) begin
            if (modem_en[k]) img_ovr[k] = modem_led[k];
        end
        for (int k = 0; k < 3; k++) begin
            if (phya_en[k]) img_ovr[2 + k] = phy_a_led[k];
            if (phyb_en[k]) img_ovr[5 + k] = phy_b_led[k];
        end
    end

    led_shift_seq #(.PHASE_CYC(PHASE_CYC), .NB_W(NB_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (sw_trig || tick),
        .nbits_i    (nbits),
        .img_i      (img_ovr),
        .falling_i  (falling),
        .sh_clk_o   (sh_clk),
        .sh_data_o  (sh_data),
        .sh_store_o (sh_store)
    );

    AST_STORE_CLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sh_store |-> (sh_clk == falling)); // R6
endmodule

// File: tb/tb_led_shift_ctrl.sv
module tb_led_shift_ctrl;
    localparam int HZ = 800;
    localparam int PH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [1:0]  modem_led = '0;
    logic [2:0]  phy_a_led = '0, phy_b_led = '0;
    logic        sh_clk, sh_data, sh_store;

    always #4 clk = ~clk;

    led_shift_ctrl #(.CLK_HZ(HZ), .PHASE_CYC(PH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .modem_led(modem_led), .phy_a_led(phy_a_led), .phy_b_led(phy_b_led),
        .sh_clk(sh_clk), .sh_data(sh_data), .sh_store(sh_store)
    );

    typedef struct {
        int          len;
        logic [23:0] val;
        string       req;
    } frame_t;

    frame_t      exp_q[$];
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;
    logic [31:0] m_ctl0 = 32'h0400_0000, m_ctl1 = '0, m_dat0 = '0;
    bit          mode_falling = 1, auto_mode = 0;
    int          store_cnt = 0, last_store = 0, interval = 0, cyc = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic int exp_len();
        if (m_ctl1[2]) return 24;
        if (m_ctl1[1]) return 16;
        if (m_ctl1[0]) return 8;
        return 0;
    endfunction

    function automatic logic [23:0] exp_img();
        logic [23:0] v;
        int          n;
        v = m_dat0[23:0];
        for (int k = 0; k < 2; k++) if (m_ctl0[24 + k]) v[k] = modem_led[k];
        for (int k = 0; k < 3; k++) begin
            if (m_ctl0[27 + k]) v[2 + k] = phy_a_led[k];
            if (m_ctl1[15 + k]) v[5 + k] = phy_b_led[k];
        end
        n = exp_len();
        if (n < 24) v = v & ((24'h1 << n) - 24'h1);
        return v;
    endfunction

    task automatic raw_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    // driver: updates the model and pushes the frame a trigger should produce
    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string req);
        bit trig;
        trig = (a == 5'h00 && d[31]) || (a == 5'h08 && m_ctl0[31]);
        if (a == 5'h00) m_ctl0 = d;
        if (a == 5'h04) m_ctl1 = d;
        if (a == 5'h08) m_dat0 = d;
        if (trig && exp_len() > 0) begin
            frame_t f;
            f.len = exp_len(); f.val = exp_img(); f.req = req;
            exp_q.push_back(f);
        end
        raw_wr(a, d);
    endtask

    task automatic settle();
        repeat (120) @(negedge clk);
    endtask

    task automatic wrs(input logic [4:0] a, input logic [31:0] d, input string req);
        wr(a, d, req);
        settle();
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(bus_rdata == e, req, bus_rdata, e);
    endtask

    // monitor: rebuilds frames from the pins and compares them with the queue
    logic        prev_clk = 1, prev_store = 0;
    logic [23:0] cap = '0;
    int          nb = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_clk == mode_falling && sh_clk != mode_falling) begin
                cap = {cap[22:0], sh_data};
                nb++;
            end
            if (sh_store && prev_store) chk(0, "R5 store wider than one cycle", 1, 0);
            if (sh_store && !prev_store) begin
                store_cnt++;
                interval = cyc - last_store;
                last_store = cyc;
                if (auto_mode) begin
                    chk(nb == exp_len() && cap == exp_img(), "R9 auto frame",
                        {8'(nb), cap}, {8'(exp_len()), exp_img()});
                end else if (exp_q.size() == 0) begin
                    chk(0, "R10/R3 unexpected frame", {8'(nb), cap}, 0);
                end else begin
                    frame_t f;
                    f = exp_q.pop_front();
                    chk(nb == f.len && cap == f.val, {f.req, " R5 frame"},
                        {8'(nb), cap}, {8'(f.len), f.val});
                end
                cap = '0;
                nb = 0;
            end
            prev_clk = sh_clk;
            prev_store = sh_store;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        @(negedge clk);
        chk(sh_clk == 1'b1, "R1 clk idle", {31'b0, sh_clk}, 1);
        chk(sh_store == 1'b0 && sh_data == 1'b0, "R1 store/data idle", {sh_store, sh_data}, 0);
        rd_chk(5'h00, 32'h0400_0000, "R1 ctl0");
        rd_chk(5'h04, 32'h0, "R1 ctl1");
        rd_chk(5'h08, 32'h0, "R1 dat0");
        rd_chk(5'h0C, 32'h0, "R1 dat1");
        rd_chk(5'h10, 32'h0, "R1 acc");
        // R2 readback
        wr(5'h0C, 32'hA5A5_5A5A, "R2");
        wr(5'h10, 32'h1234_5678, "R2");
        wr(5'h04, 32'h0000_0001, "R2");
        rd_chk(5'h0C, 32'hA5A5_5A5A, "R2 dat1");
        rd_chk(5'h10, 32'h1234_5678, "R2 acc");
        rd_chk(5'h04, 32'h0000_0001, "R2 ctl1");
        // R3 software trigger
        s = store_cnt;
        wrs(5'h08, 32'h0000_00C3, "R3");
        chk(store_cnt == s, "R3 no trigger without swmode", store_cnt, s);
        rd_chk(5'h08, 32'h0000_00C3, "R2 dat0");
        wrs(5'h00, 32'h8400_0000, "R3");
        rd_chk(5'h00, 32'h8400_0000, "R2 ctl0");
        wrs(5'h08, 32'h0000_005A, "R3");
        // R4 frame lengths
        wr(5'h04, 32'h0000_0002, "R4");
        wrs(5'h08, 32'h0000_ABCD, "R4");
        wr(5'h04, 32'h0000_0005, "R4");
        wrs(5'h08, 32'h0012_3456, "R4");
        wr(5'h04, 32'h0000_0000, "R4");
        s = store_cnt;
        wrs(5'h08, 32'h0000_0077, "R4");
        chk(store_cnt == s, "R4 no groups no frame", store_cnt, s);
        wr(5'h04, 32'h0000_0001, "R4");
        // R6 edge polarity
        mode_falling = 0;
        wrs(5'h00, 32'h8000_0000, "R6");
        chk(sh_clk == 1'b0, "R6 rising-mode idle low", {31'b0, sh_clk}, 0);
        wrs(5'h08, 32'h0000_0096, "R6");
        mode_falling = 1;
        wrs(5'h00, 32'h8400_0000, "R6");
        chk(sh_clk == 1'b1, "R6 falling-mode idle high", {31'b0, sh_clk}, 1);
        // R7 modem override
        modem_led = 2'b11;
        wrs(5'h00, 32'h8600_0000, "R7");
        wrs(5'h08, 32'h0000_0000, "R7");
        modem_led = 2'b00;
        wrs(5'h08, 32'h0000_00FF, "R7");
        // R8 PHY overrides
        wr(5'h04, 32'h0001_8001, "R8");
        phy_a_led = 3'b111; phy_b_led = 3'b010;
        wrs(5'h00, 32'hAC00_0000, "R8");
        wrs(5'h08, 32'h0000_0000, "R8");
        phy_a_led = 3'b000; phy_b_led = 3'b000;
        wrs(5'h08, 32'h0000_00FF, "R8");
        // R10 trigger while busy
        s = store_cnt;
        wr(5'h00, 32'h8400_0000, "R10");
        repeat (6) @(negedge clk);
        raw_wr(5'h00, 32'h8400_0000);
        raw_wr(5'h08, m_dat0);
        settle();
        chk(store_cnt == s + 1, "R10 one frame only", store_cnt, s + 1);
        // R9 automatic refresh
        wrs(5'h00, 32'h0400_0000, "R9");
        wrs(5'h08, 32'h0000_003C, "R9");
        auto_mode = 1;
        wr(5'h04, 32'h8000_0001 | (32'd1 << 23), "R9");
        repeat (700) @(negedge clk);
        chk(interval == HZ / 4, "R9 4 Hz period", interval, HZ / 4);
        wr(5'h04, 32'h8000_0001 | (32'd3 << 23), "R9");
        repeat (300) @(negedge clk);
        chk(interval == HZ / 10, "R9 10 Hz period", interval, HZ / 10);
        wr(5'h04, 32'h4000_0001 | (32'd3 << 23), "R9");
        repeat (100) @(negedge clk);
        s = store_cnt;
        repeat (500) @(negedge clk);
        chk(store_cnt == s, "R9 other source stops auto", store_cnt, s);
        auto_mode = 0;
        chk(exp_q.size() == 0, "R5 all expected frames seen", exp_q.size(), 0);
        finish_run();
    end
endmodule